// File: doc/BRIEF.md
# Return-Address Shift Stack

A small fixed-depth stack that keeps program-counter return addresses for a compact processor core. When the core enters a subroutine or an interrupt, it strobes `push_en` with the address to come back to. When it executes a return, it strobes `pop_en` and takes the address from `top_addr` in that same cycle. Levels are numbered from 0 (the top) to DEPTH-1 (the bottom). Each push moves every level one step deeper. Each pop moves every level one step toward the top.

The block has no occupancy tracking and raises no flags. A push into a full stack silently drops the entry that was written first. A pop leaves the bottom level as it was, so every level above it can fill up with copies of that bottom value. If there are more returns than calls, the core therefore receives the oldest surviving address again rather than an undefined value.

Each cycle, a small decoder turns the two strobes into one of four operations: `OP_HOLD` (neither strobe), `OP_PUSH` (push only), `OP_POP` (pop only) and `OP_SWAP` (both strobes). The operation is picked anew from the strobes in every cycle. Any operation may follow any other, and no sequence of operations is carried between cycles. Each level register then updates according to the chosen operation.

Top module: `ras_shift_stack`

## Requirements
- R1: A synchronous reset clears every level to zero. After reset, `top_addr` reads 0, and pops with no pushes in between keep returning 0.
- R2: `top_addr` is combinational from level 0. While `pop_en` is high, it already shows the address being returned in that same cycle, before the clock edge.
- R3: With `push_en`=1 and `pop_en`=0, at the clock edge level 0 takes `push_addr`, level 1 takes the old level 0, and level 2 takes the old level 1.
- R4: With `pop_en`=1 and `push_en`=0, at the clock edge level 0 takes the old level 1 and level 1 takes the old level 2.
- R5: On a pop, the bottom level (level 2) keeps its value, so the bottom address is copied upward rather than cleared.
- R6: A fourth push in a row discards the first address pushed. Only the three most recent pushes stay reachable.
- R7: With both strobes high, level 0 is replaced by `push_addr` and levels 1 and 2 are unchanged.
- R8: Pushing A1, A2, A3, A4 and then popping four times returns A4, A3, A2, A2, in that order.
- R9: With neither strobe high, all levels keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, clears all levels |
| push_en | input | 1 | Push strobe (call or interrupt entry) |
| pop_en | input | 1 | Pop strobe (return) |
| push_addr | input | 9 | Return address to store on a push |
| top_addr | output | 9 | Current level-0 address (combinational) |

## Verification
The bench builds the block with its default values, DEPTH=3 and WIDTH=9. With those values, overflow is reached by the fourth push in a row, and the copied-bottom behaviour shows up after only one pop of a full stack. Both are exercised many times within a short run. Because the width is nine bits, the directed cases can use the all-ones address 0x1FF and zero next to ordinary values, so a dropped or stuck bit shows up at `top_addr`. A long random mix of all four operations is compared every cycle against a queue model in the bench.

// File: rtl/ras_pkg.sv
package ras_pkg;
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_SWAP = 2'd3
    } ras_op_e;
endpackage

// File: rtl/ras_op_decode.sv
module ras_op_decode
    import ras_pkg::*;
(
    input  logic    push_en,
    input  logic    pop_en,
    output ras_op_e op
);
    always_comb begin
        unique case ({push_en, pop_en})
            2'b00: op = OP_HOLD;
            2'b10: op = OP_PUSH;
            2'b01: op = OP_POP;
            2'b11: op = OP_SWAP;
        endcase
    end
endmodule

// File: rtl/ras_level_cell.sv
module ras_level_cell
    import ras_pkg::*;
#(
    parameter int  WIDTH  = 9,
    parameter bit  IS_TOP = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  ras_op_e          op,
    input  logic [WIDTH-1:0] shift_in,
    input  logic [WIDTH-1:0] lift_in,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] q_next;

    always_comb begin
        unique case (op)
            OP_HOLD: q_next = q;
            OP_PUSH: q_next = shift_in;
            OP_POP:  q_next = lift_in;
            OP_SWAP: q_next = IS_TOP ? shift_in : q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= q_next;
    end
endmodule

// File: rtl/ras_shift_stack.sv
module ras_shift_stack
    import ras_pkg::*;
#(
    parameter int WIDTH = 9,
    parameter int DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_en,
    input  logic             pop_en,
    input  logic [WIDTH-1:0] push_addr,
    output logic [WIDTH-1:0] top_addr
);
    localparam int LAST = DEPTH - 1;

    ras_op_e          op;
    logic [WIDTH-1:0] lvl      [DEPTH];
    logic [WIDTH-1:0] shift_in [DEPTH];
    logic [WIDTH-1:0] lift_in  [DEPTH];

    ras_op_decode u_dec (
        .push_en (push_en),
        .pop_en  (pop_en),
        .op      (op)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
        if (i == 0) begin : g_first
            assign shift_in[i] = push_addr;
        end else begin : g_deeper
            assign shift_in[i] = lvl[i-1];
        end
        if (i == LAST) begin : g_bottom
            assign lift_in[i] = lvl[i];
        end else begin : g_upper
            assign lift_in[i] = lvl[i+1];
        end

        ras_level_cell #(
            .WIDTH  (WIDTH),
            .IS_TOP (i == 0)
        ) u_cell (
            .clk      (clk),
            .rst      (rst),
            .op       (op),
            .shift_in (shift_in[i]),
            .lift_in  (lift_in[i]),
            .q        (lvl[i])
        );
    end

    assign top_addr = lvl[0];

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (top_addr == '0));

    // R3
    push_load_chk: assert property (@(posedge clk) disable iff (rst)
        (push_en && !pop_en) |=> (top_addr == $past(push_addr)));

    for (genvar j = 1; j < DEPTH; j++) begin : g_chk
        // R3
        push_shift_chk: assert property (@(posedge clk) disable iff (rst)
            (push_en && !pop_en) |=> (lvl[j] == $past(lvl[j-1])));
        // R4
        pop_lift_chk: assert property (@(posedge clk) disable iff (rst)
            (pop_en && !push_en) |=> (lvl[j-1] == $past(lvl[j])));
        // R7
        swap_keep_chk: assert property (@(posedge clk) disable iff (rst)
            (push_en && pop_en) |=> (lvl[j] == $past(lvl[j])));
    end

    // R5
    bottom_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (pop_en && !push_en) |=> (lvl[LAST] == $past(lvl[LAST])));

    // R7
    swap_top_chk: assert property (@(posedge clk) disable iff (rst)
        (push_en && pop_en) |=> (top_addr == $past(push_addr)));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!push_en && !pop_en) |=> ($stable(top_addr) && $stable(lvl[LAST])));
endmodule

// File: tb/ras_shift_stack_tb.sv
module ras_shift_stack_tb;
    localparam int  WIDTH    = 9;
    localparam int  DEPTH    = 3;
    localparam time CLK_HALF = 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             push_en = 1'b0;
    logic             pop_en = 1'b0;
    logic [WIDTH-1:0] push_addr = '0;
    logic [WIDTH-1:0] top_addr;

    int  n_vec  = 0;
    int  n_miss = 0;
    bit  done   = 1'b0;
    int  model[$];

    always #(CLK_HALF) clk = ~clk;

    ras_shift_stack #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .push_en   (push_en),
        .pop_en    (pop_en),
        .push_addr (push_addr),
        .top_addr  (top_addr)
    );

    task automatic check(input string tag, input int exp);
        n_vec++;
        if (int'(top_addr) != exp) begin
            n_miss++;
            $display("FAIL %s: top_addr=%h expected=%h", tag, top_addr, exp[WIDTH-1:0]);
        end
    endtask

    task automatic model_reset();
        model.delete();
        for (int k = 0; k < DEPTH; k++) model.push_back(0);
    endtask

    task automatic model_step(input bit pu, input bit po, input int a);
        if (pu && po) begin
            model[0] = a;
        end else if (pu) begin
            model.push_front(a);
            void'(model.pop_back());
        end else if (po) begin
            void'(model.pop_front());
            model.push_back(model[model.size()-1]);
        end
    endtask

    // Drive at falling edge, check combinational top (R2), clock, update model.
    task automatic step(input bit pu, input bit po, input int a, input string tag);
        @(negedge clk);
        push_en = pu; pop_en = po; push_addr = a[WIDTH-1:0];
        #1;
        check({tag, "/R2"}, model[0]);
        @(posedge clk);
        model_step(pu, po, a);
        #1;
        check(tag, model[0]);
    endtask

    // Pop and compare the same-cycle returned value with a fixed expectation.
    task automatic pop_expect(input int exp, input string tag);
        @(negedge clk);
        push_en = 1'b0; pop_en = 1'b1;
        #1;
        check(tag, exp);
        @(posedge clk);
        model_step(1'b0, 1'b1, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; push_en = 1'b0; pop_en = 1'b0;
        @(posedge clk);
        model_reset();
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_HALF * 2 * 100000);
        if (!done) begin
            n_miss++;
            $display("FAIL watchdog: top_addr=%h expected=end of run", top_addr);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end

    initial begin
        model_reset();
        @(posedge clk);
        @(posedge clk);
        #1;
        check("R1 reset", 0);
        @(negedge clk);
        rst = 1'b0;
        // R1: pops on a fresh stack return zero
        pop_expect(0, "R1 pop after reset");
        pop_expect(0, "R1 second pop after reset");

        // R8 / R6: four pushes then four pops
        step(1, 0, 9'h011, "R3 push A1");
        step(1, 0, 9'h122, "R3 push A2");
        step(1, 0, 9'h1FF, "R3 push A3");
        step(1, 0, 9'h000, "R6 push A4 overflow");
        pop_expect(9'h000, "R8 pop A4");
        pop_expect(9'h1FF, "R8 pop A3");
        pop_expect(9'h122, "R8 pop A2");
        pop_expect(9'h122, "R8 pop A2 again R5");
        pop_expect(9'h122, "R5 bottom copied");

        // R7: swap replaces top only
        do_reset();
        step(1, 0, 9'h0A1, "R3 push");
        step(1, 0, 9'h0B2, "R3 push");
        step(1, 1, 9'h1C3, "R7 swap");
        pop_expect(9'h1C3, "R7 new top");
        pop_expect(9'h0A1, "R7 level1 kept");
        pop_expect(0, "R7 level2 kept");

        // R9: idle holds
        do_reset();
        step(1, 0, 9'h155, "R3 push");
        for (int k = 0; k < 4; k++) step(0, 0, 9'h0AA, "R9 idle hold");
        pop_expect(9'h155, "R9 value held");

        // R4 / R6: five pushes, oldest two lost
        do_reset();
        for (int k = 1; k <= 5; k++) step(1, 0, k * 7, "R6 push run");
        pop_expect(35, "R4 pop 5");
        pop_expect(28, "R4 pop 4");
        pop_expect(21, "R6 pop 3");
        pop_expect(21, "R6 oldest gone");

        // Random mix against the model
        for (int k = 0; k < 3000; k++) begin
            int r = $urandom_range(0, 3);
            step(r[1], r[0], $urandom_range(0, 511), "R3/R4/R7/R9 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end
endmodule